// File: doc/BRIEF.md
# Tile Hidden-Surface Removal Unit

This unit finds the visible surface of every pixel in one 16 by 16 screen tile before any shading is done. A tile begins with a start pulse, which resets an on-chip depth store to the farthest value and marks every pixel as uncovered. Rasterized fragments then arrive on a valid/ready port. Each fragment carries a pixel position inside the tile, a depth and a primitive identifier. No colour or texture data enters the unit. Each fragment is compared with the depth already held for its pixel. When it is nearer, it replaces both the stored depth and the stored primitive identifier.

When the tile's geometry is finished, an end pulse starts the readout. The unit walks every pixel of the tile and emits one record for each pixel that some primitive covers. The record holds the pixel position and the identifier of the front-most primitive. Records leave on a valid/ready port toward a later shading stage. Uncovered pixels produce nothing. A one-cycle done pulse closes the tile, and the unit is then ready for the next tile of the frame. Shading is therefore deferred: downstream logic sees only surviving pixels, and only after all geometry of the tile has been tested.

Top module: `tile_hsr`

## Requirements
- R1: After reset, `frag_ready`, `out_valid` and `tile_done` are all low, and the unit waits for a tile start.
- R2: A `tile_start` pulse in the idle state clears every pixel to the maximum depth (all ones) and to uncovered. `frag_ready` stays low for exactly 256 cycles and rises afterwards.
- R3: A fragment wins its pixel only when its depth is strictly less than the stored depth. The winner replaces the stored depth and the stored primitive. An equal or greater depth leaves both unchanged.
- R4: Fragments are accepted one per cycle. A fragment that follows directly behind another fragment for the same pixel is tested against the result of that earlier fragment.
- R5: A fragment whose depth is the maximum value (all ones) never covers a pixel.
- R6: A `tile_end` pulse while fragments are accepted starts the readout. The readout visits pixels in ascending index order, index = y*16 + x (x in the low four bits). For each covered pixel it emits one record of x, y and the winning primitive, and it skips uncovered pixels.
- R7: `frag_ready` is low from the end of the tile until the tile's done pulse, so no fragment is taken during readout.
- R8: While `out_valid` is high and `out_ready` is low, the record and `out_valid` hold unchanged.
- R9: `tile_done` is a one-cycle pulse. It comes after the last pixel is scanned and after the last record is taken. A tile with no covered pixel gives the pulse and no record.
- R10: `tile_start` is ignored outside the idle state. `tile_end` is ignored outside the fragment-accepting state.
- R11: Each tile starts empty: no record of an earlier tile appears in a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_start | input | 1 | Begin a new tile (clear) |
| tile_end | input | 1 | Geometry of the tile finished, start readout |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Fragment accepted this cycle when valid |
| frag_x | input | 4 | Pixel column inside the tile |
| frag_y | input | 4 | Pixel row inside the tile |
| frag_depth | input | 16 | Fragment depth, smaller is nearer |
| frag_prim | input | 12 | Primitive identifier |
| out_valid | output | 1 | Visible-pixel record present |
| out_ready | input | 1 | Downstream takes the record |
| out_x | output | 4 | Record pixel column |
| out_y | output | 4 | Record pixel row |
| out_prim | output | 12 | Front-most primitive of that pixel |
| tile_done | output | 1 | One-cycle pulse when the tile's readout ends |

## Verification
The depth test is driven with three orderings on one pixel: nearer fragments last, nearer fragments first, and ties. These separate a strict comparison from a less-or-equal one and show whether a losing fragment still writes the stored primitive. Back-to-back bursts on one pixel expose any read-after-write hazard in the pipelined store. Far-plane fragments, an empty tile and a tile that follows a busy one show whether coverage comes from the cleared state or from stale data. Fragments sent in reverse screen order, together with a stalling downstream, check the row-major output order and that each record holds while stalled.

// File: rtl/tile_hsr_pkg.sv
package tile_hsr_pkg;

  // Tile-level sequencing
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ACCEPT,
    ST_FLUSH,
    ST_SCAN
  } hsr_state_e;

  // Readout walker
  typedef enum logic [1:0] {
    SC_IDLE,
    SC_READ,
    SC_CHECK,
    SC_HOLD
  } scan_state_e;

endpackage

// File: rtl/hsr_store.sv
// Per-pixel depth and tag memories: one write port, one synchronous read port
// (read returns the value held before a same-edge write).
module hsr_store #(
  parameter int ADDR_W  = 8,
  parameter int DEPTH_W = 16,
  parameter int TAG_W   = 13
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [DEPTH_W-1:0] wdepth,
  input  logic [TAG_W-1:0]   wtag,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [DEPTH_W-1:0] rdepth,
  output logic [TAG_W-1:0]   rtag
);
  localparam int NPIX = 1 << ADDR_W;

  logic [DEPTH_W-1:0] depth_mem [NPIX];
  logic [TAG_W-1:0]   tag_mem   [NPIX];

  always_ff @(posedge clk) begin
    if (we) depth_mem[waddr] <= wdepth;
    rdepth <= depth_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) tag_mem[waddr] <= wtag;
    rtag <= tag_mem[raddr];
  end
endmodule

// File: rtl/hsr_depth_stage.sv
// One-stage depth compare behind the synchronous read, with a bypass of the
// write issued on the previous cycle (that write lands on the same edge as
// the read and is therefore not seen by it).
module hsr_depth_stage #(
  parameter int ADDR_W  = 8,
  parameter int DEPTH_W = 16,
  parameter int PRIM_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [DEPTH_W-1:0] in_depth,
  input  logic [PRIM_W-1:0]  in_prim,
  input  logic [DEPTH_W-1:0] mem_depth,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DEPTH_W-1:0] wr_depth,
  output logic [PRIM_W-1:0]  wr_prim
);
  logic               s_vld;
  logic [ADDR_W-1:0]  s_addr;
  logic [DEPTH_W-1:0] s_depth;
  logic [PRIM_W-1:0]  s_prim;

  logic               byp_vld;
  logic [ADDR_W-1:0]  byp_addr;
  logic [DEPTH_W-1:0] byp_depth;

  logic [DEPTH_W-1:0] cur_depth;
  logic               wins;

  always_comb begin
    cur_depth = (byp_vld && (byp_addr == s_addr)) ? byp_depth : mem_depth;
    wins      = s_vld && (s_depth < cur_depth);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_vld     <= 1'b0;
      s_addr    <= '0;
      s_depth   <= '0;
      s_prim    <= '0;
      byp_vld   <= 1'b0;
      byp_addr  <= '0;
      byp_depth <= '0;
    end else begin
      s_vld   <= in_vld;
      s_addr  <= in_addr;
      s_depth <= in_depth;
      s_prim  <= in_prim;
      byp_vld <= wins;
      if (wins) begin
        byp_addr  <= s_addr;
        byp_depth <= s_depth;
      end
    end
  end

  assign wr_en    = wins;
  assign wr_addr  = s_addr;
  assign wr_depth = s_depth;
  assign wr_prim  = s_prim;
endmodule

// File: rtl/hsr_scan.sv
// Row-major readout walker: reads each tag, forwards covered pixels on a
// registered valid/ready port, pulses done after the last pixel.
module hsr_scan
  import tile_hsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRIM_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PRIM_W:0]   rd_tag,
  output logic [ADDR_W-1:0] scan_addr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [PRIM_W-1:0] out_prim,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  scan_state_e       st;
  logic [ADDR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SC_IDLE;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_prim  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        SC_IDLE: if (start) begin
          cnt <= '0;
          st  <= SC_READ;
        end
        SC_READ: st <= SC_CHECK;
        SC_CHECK: begin
          if (rd_tag[PRIM_W]) begin
            out_valid <= 1'b1;
            out_addr  <= cnt;
            out_prim  <= rd_tag[PRIM_W-1:0];
            st        <= SC_HOLD;
          end else if (cnt == LAST) begin
            done <= 1'b1;
            st   <= SC_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= SC_READ;
          end
        end
        SC_HOLD: if (out_ready) begin
          out_valid <= 1'b0;
          if (cnt == LAST) begin
            done <= 1'b1;
            st   <= SC_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= SC_READ;
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

  assign scan_addr = cnt;
endmodule

// File: rtl/tile_hsr.sv
module tile_hsr
  import tile_hsr_pkg::*;
#(
  parameter int X_W     = 4,
  parameter int Y_W     = 4,
  parameter int DEPTH_W = 16,
  parameter int PRIM_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tile_start,
  input  logic               tile_end,
  input  logic               frag_valid,
  output logic               frag_ready,
  input  logic [X_W-1:0]     frag_x,
  input  logic [Y_W-1:0]     frag_y,
  input  logic [DEPTH_W-1:0] frag_depth,
  input  logic [PRIM_W-1:0]  frag_prim,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [X_W-1:0]     out_x,
  output logic [Y_W-1:0]     out_y,
  output logic [PRIM_W-1:0]  out_prim,
  output logic               tile_done
);
  localparam int ADDR_W = X_W + Y_W;
  localparam int TAG_W  = PRIM_W + 1;
  localparam logic [ADDR_W-1:0] LAST_PIX = {ADDR_W{1'b1}};

  hsr_state_e        state;
  logic [ADDR_W-1:0] clr_cnt;

  logic               st_we;
  logic [ADDR_W-1:0]  st_waddr, st_raddr;
  logic [DEPTH_W-1:0] st_wdepth, st_rdepth;
  logic [TAG_W-1:0]   st_wtag, st_rtag;

  logic               cmp_we;
  logic [ADDR_W-1:0]  cmp_addr;
  logic [DEPTH_W-1:0] cmp_depth;
  logic [PRIM_W-1:0]  cmp_prim;

  logic [ADDR_W-1:0]  scan_addr, rec_addr;
  logic               scan_done;
  logic               frag_take;

  assign frag_ready = (state == ST_ACCEPT);
  assign frag_take  = frag_valid && frag_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      clr_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (tile_start) begin
          clr_cnt <= '0;
          state   <= ST_CLEAR;
        end
        ST_CLEAR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == LAST_PIX) state <= ST_ACCEPT;
        end
        ST_ACCEPT: if (tile_end) state <= ST_FLUSH;
        ST_FLUSH:  state <= ST_SCAN;
        ST_SCAN:   if (scan_done) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // Single write port shared by the clear sweep and the depth stage
  always_comb begin
    if (state == ST_CLEAR) begin
      st_we     = 1'b1;
      st_waddr  = clr_cnt;
      st_wdepth = {DEPTH_W{1'b1}};
      st_wtag   = '0;
    end else begin
      st_we     = cmp_we;
      st_waddr  = cmp_addr;
      st_wdepth = cmp_depth;
      st_wtag   = {1'b1, cmp_prim};
    end
    st_raddr = (state == ST_ACCEPT) ? {frag_y, frag_x} : scan_addr;
  end

  hsr_store #(
    .ADDR_W (ADDR_W),
    .DEPTH_W(DEPTH_W),
    .TAG_W  (TAG_W)
  ) u_store (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdepth(st_wdepth),
    .wtag  (st_wtag),
    .raddr (st_raddr),
    .rdepth(st_rdepth),
    .rtag  (st_rtag)
  );

  hsr_depth_stage #(
    .ADDR_W (ADDR_W),
    .DEPTH_W(DEPTH_W),
    .PRIM_W (PRIM_W)
  ) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (frag_take),
    .in_addr  ({frag_y, frag_x}),
    .in_depth (frag_depth),
    .in_prim  (frag_prim),
    .mem_depth(st_rdepth),
    .wr_en    (cmp_we),
    .wr_addr  (cmp_addr),
    .wr_depth (cmp_depth),
    .wr_prim  (cmp_prim)
  );

  hsr_scan #(
    .ADDR_W(ADDR_W),
    .PRIM_W(PRIM_W)
  ) u_scan (
    .clk      (clk),
    .rst      (rst),
    .start    (state == ST_FLUSH),
    .rd_tag   (st_rtag),
    .scan_addr(scan_addr),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_addr (rec_addr),
    .out_prim (out_prim),
    .done     (scan_done)
  );

  assign out_x     = rec_addr[X_W-1:0];
  assign out_y     = rec_addr[ADDR_W-1:X_W];
  assign tile_done = scan_done;
endmodule

// File: rtl/tile_hsr_checker.sv
module tile_hsr_checker #(
  parameter int X_W    = 4,
  parameter int Y_W    = 4,
  parameter int PRIM_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              frag_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [X_W-1:0]    out_x,
  input logic [Y_W-1:0]    out_y,
  input logic [PRIM_W-1:0] out_prim,
  input logic              tile_done
);
  // R8: a stalled record keeps its valid flag
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R8: a stalled record keeps its contents
  a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_x) && $stable(out_y) && $stable(out_prim)));

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    tile_done |=> !tile_done);

  // R9: done only once the last record has gone
  a_r9_done_after_drain: assert property (@(posedge clk) disable iff (rst)
    tile_done |-> !out_valid);

  // R7: no fragment is taken while records are offered
  a_r7_no_input_in_readout: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !frag_ready);

  // R7: readout never overlaps fragment intake at the done pulse
  a_r7_no_input_at_done: assert property (@(posedge clk) disable iff (rst)
    tile_done |-> !frag_ready);
endmodule

bind tile_hsr tile_hsr_checker #(
  .X_W   (X_W),
  .Y_W   (Y_W),
  .PRIM_W(PRIM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frag_ready(frag_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_prim  (out_prim),
  .tile_done (tile_done)
);

// File: tb/tile_hsr_tb.sv
module tile_hsr_tb;
  localparam int NPIX = 256;

  logic        clk = 1'b0;
  logic        rst;
  logic        tile_start, tile_end, frag_valid, frag_ready;
  logic [3:0]  frag_x, frag_y, out_x, out_y;
  logic [15:0] frag_depth;
  logic [11:0] frag_prim, out_prim;
  logic        out_valid, out_ready, tile_done;

  always #5 clk = ~clk;

  tile_hsr u_dut (
    .clk(clk), .rst(rst), .tile_start(tile_start), .tile_end(tile_end),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_x(frag_x),
    .frag_y(frag_y), .frag_depth(frag_depth), .frag_prim(frag_prim),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x),
    .out_y(out_y), .out_prim(out_prim), .tile_done(tile_done)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model of one tile
  int m_depth [NPIX];
  bit m_cov   [NPIX];
  int m_prim  [NPIX];

  // Records seen at the output
  int r_x [NPIX+8];
  int r_y [NPIX+8];
  int r_p [NPIX+8];
  int r_n;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NPIX; i++) begin
      m_depth[i] = 65535;
      m_cov[i]   = 1'b0;
      m_prim[i]  = 0;
    end
  endtask

  // Starts a tile from idle; returns how many cycles frag_ready stayed low
  task automatic start_tile(output int low_cycles);
    @(negedge clk);
    tile_start = 1'b1;
    @(negedge clk);
    tile_start = 1'b0;
    low_cycles = 0;
    while (!frag_ready && low_cycles < 2000) begin
      low_cycles++;
      @(negedge clk);
    end
    model_clear();
  endtask

  task automatic send(input int x, input int y, input int d, input int p);
    int idx;
    frag_x = 4'(x); frag_y = 4'(y); frag_depth = 16'(d); frag_prim = 12'(p);
    frag_valid = 1'b1;
    while (!frag_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    frag_valid = 1'b0;
    idx = y * 16 + x;
    if (d < m_depth[idx]) begin
      m_depth[idx] = d;
      m_prim[idx]  = p;
      m_cov[idx]   = 1'b1;
    end
  endtask

  task automatic end_tile();
    frag_valid = 1'b0;
    tile_end = 1'b1;
    @(posedge clk); #1;
    tile_end = 1'b0;
  endtask

  // Collects the readout; stall=1 applies backpressure two cycles of three
  task automatic collect(input bit stall);
    bit got_done = 1'b0;
    bit prev_hold = 1'b0;
    bit ready_seen = 1'b0;
    int hx = 0, hy = 0, hp = 0;
    int exp_n = 0;
    r_n = 0;
    for (int cyc = 0; cyc < 4000 && !got_done; cyc++) begin
      @(negedge clk);
      if (frag_ready) ready_seen = 1'b1;
      if (prev_hold) begin
        check_eq("R8", "valid held", int'(out_valid), 1);
        check_eq("R8", "x held", int'(out_x), hx);
        check_eq("R8", "y held", int'(out_y), hy);
        check_eq("R8", "prim held", int'(out_prim), hp);
      end
      out_ready = stall ? ((cyc % 3) == 2) : 1'b1;
      if (out_valid && out_ready && r_n < NPIX + 8) begin
        r_x[r_n] = int'(out_x);
        r_y[r_n] = int'(out_y);
        r_p[r_n] = int'(out_prim);
        r_n++;
      end
      prev_hold = out_valid && !out_ready;
      hx = int'(out_x); hy = int'(out_y); hp = int'(out_prim);
      if (tile_done) begin
        got_done = 1'b1;
        check_eq("R9", "valid low at done", int'(out_valid), 0);
      end
    end
    out_ready = 1'b0;
    check_eq("R9", "done seen", int'(got_done), 1);
    check_eq("R7", "frag_ready during readout", int'(ready_seen), 0);
    @(negedge clk);
    check_eq("R9", "done one cycle", int'(tile_done), 0);
    // Expected records, row-major
    for (int i = 0; i < NPIX; i++) begin
      if (m_cov[i]) begin
        if (exp_n < r_n) begin
          check_eq("R6", "record x", r_x[exp_n], i % 16);
          check_eq("R6", "record y", r_y[exp_n], i / 16);
          check_eq("R3", "record prim", r_p[exp_n], m_prim[i]);
        end
        exp_n++;
      end
    end
    check_eq("R6", "record count", r_n, exp_n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R1", "frag_ready after reset", int'(frag_ready), 0);
    check_eq("R1", "out_valid after reset", int'(out_valid), 0);
    check_eq("R1", "tile_done after reset", int'(tile_done), 0);
  endtask

  // Depth orderings, reverse screen order, a full row
  task automatic t_basic();
    int low;
    start_tile(low);
    check_eq("R2", "clear stall cycles", low, 256);
    send(15, 15, 900, 11);
    send(3, 0, 700, 12);
    send(0, 1, 100, 13);
    send(5, 7, 300, 14);
    send(5, 7, 200, 15);       // nearer later: wins (R3)
    send(6, 7, 200, 16);
    send(6, 7, 300, 17);       // farther later: loses (R3)
    send(7, 7, 250, 18);
    send(7, 7, 250, 19);       // tie: first stays (R3)
    for (int x = 15; x >= 0; x--) send(x, 10, 1000 + x, 100 + x);
    end_tile();
    collect(1'b0);
  endtask

  // Back-to-back same pixel, far-plane fragments, stalled output
  task automatic t_burst();
    int low;
    start_tile(low);
    check_eq("R2", "clear stall cycles again", low, 256);
    send(2, 2, 500, 1);
    send(2, 2, 400, 2);
    send(2, 2, 450, 3);
    send(2, 2, 100, 4);
    send(2, 2, 100, 5);
    send(9, 9, 65535, 6);      // never covers (R5)
    send(4, 12, 65535, 7);
    send(4, 12, 65534, 8);
    send(4, 12, 65535, 9);
    send(0, 0, 30, 20);
    send(0, 0, 20, 21);
    send(1, 0, 10, 22);
    send(0, 0, 25, 23);
    end_tile();
    collect(1'b1);
    check_eq("R4", "burst winner", m_prim[2*16+2], 4);
    check_eq("R5", "far pixel uncovered in model", int'(m_cov[9*16+9]), 0);
  endtask

  // Ignored controls
  task automatic t_ignored();
    int low;
    bit any_out = 1'b0;
    @(negedge clk);
    tile_end = 1'b1;
    @(negedge clk);
    tile_end = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (out_valid || tile_done || frag_ready) any_out = 1'b1;
    end
    check_eq("R10", "tile_end in idle ignored", int'(any_out), 0);
    start_tile(low);
    send(8, 3, 40, 31);
    send(8, 4, 41, 32);
    tile_start = 1'b1;         // during intake: must be ignored (R10)
    @(posedge clk); #1;
    tile_start = 1'b0;
    check_eq("R10", "intake continues after start", int'(frag_ready), 1);
    send(8, 5, 42, 33);
    end_tile();
    collect(1'b0);
  endtask

  // Empty tile following busy tiles
  task automatic t_empty();
    int low;
    start_tile(low);
    end_tile();
    collect(1'b0);
    check_eq("R11", "no stale records", r_n, 0);
  endtask

  initial begin
    rst = 1'b1;
    tile_start = 1'b0; tile_end = 1'b0; frag_valid = 1'b0;
    frag_x = '0; frag_y = '0; frag_depth = '0; frag_prim = '0;
    out_ready = 1'b0;
    model_clear();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_burst();
    t_ignored();
    t_empty();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule